// File: doc/BRIEF.md
# Serial Crosspoint Programming Master

This block programs a 4-input by 6-output RF crosspoint switch over a three-wire link: a serial data line, a serial clock and a latch enable. The host presents a 24-bit connection map and raises a start strobe. The block packs the map into a 32-bit control word, shifts the word out least significant bit first, and then raises latch enable once. The switch applies the new routing on that latch pulse.

Every link interval is a number of system clock cycles set by a parameter. These intervals are the serial clock half period, the data setup margin, the latch pulse width, the gap before the latch and the gap after it. A check at elaboration rejects any set of counts that would break the switch's minimum times. The block drives one switch, not a chain. It reports `busy` while a transfer runs and pulses `done` when the transfer ends.

Top module: `xbar_prog_master`

## Requirements
- R1: After a synchronous reset `serClk`, `serData`, `latchEn`, `busy` and `done` are all 0. Whenever `busy` is 0, `serClk` and `latchEn` are 0.
- R2: Map bit `mapIn[i*6+j]` (input i, output j, both counted from 0) is sent as word bit `i*8+j`. A 1 closes that connection, so `mapIn[3]` alone gives word 0x00000008.
- R3: The 32 word bits are sent lowest index first. There is one rising edge of `serClk` per bit, and exactly 32 rising edges before the latch pulse.
- R4: Word bits at offsets 6 and 7 of each 8-bit group are always sent as 0. An all-ones map gives word 0x3F3F3F3F.
- R5: Any number of outputs per input may be closed at once, and each selected output appears as its own 1 bit in the word.
- R6: `serClk` idles low. Each bit has HALF_CNT cycles low, then HALF_CNT cycles high. The first low phase begins in the cycle after the start is accepted.
- R7: `serData` changes only while `serClk` is low. It changes exactly SETUP_CNT cycles before the rising edge and holds through the whole high phase.
- R8: After the last high phase, `serClk` stays low for LEAD_GAP_CNT cycles. `latchEn` is then high for LATCH_CNT cycles. A further TRAIL_GAP_CNT cycles pass before the transfer ends. `serClk` and `latchEn` are never high together.
- R9: A start request that arrives while `busy` is 1 is ignored. It neither starts a second transfer nor changes the current one.
- R10: The map is captured in the cycle the start is accepted. Changes to `mapIn` after that do not alter the word being sent.
- R11: `done` is high for exactly one cycle, right after the trailing gap, and `busy` is 0 in that cycle. `serData` returns to 0 then. A new start is accepted in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| mapIn | input | 24 | Connection map, bit i*6+j closes input i to output j |
| startReq | input | 1 | Start strobe, taken when not busy |
| serClk | output | 1 | Serial clock to the switch |
| serData | output | 1 | Serial data to the switch |
| latchEn | output | 1 | Latch enable to the switch |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle pulse at the end of a transfer |

## Verification
The bench sends a single-connection map and compares the shifted word with 0x00000008. A design that reverses the bit order or packs the map without the gaps sends a different word. An all-ones map finds any leak into the unused offsets: the word then differs from 0x3F3F3F3F. During one transfer the bench pulses start again and changes the map. A design that restarts on that pulse, or reads the map live, shows a second busy period or a wrong word. A run that holds start high across the done cycle checks that a new transfer begins at once. Comparison on every cycle catches a data change in the wrong cycle, and a latch pulse or gap that is one cycle short.

// File: rtl/xbar_prog_pkg.sv
package xbar_prog_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_LOW,
    PH_HIGH,
    PH_LEAD,
    PH_LATCH,
    PH_TRAIL
  } phase_t;

  // strobes from control to datapath
  typedef struct packed {
    logic load;   // capture packed map into shift register
    logic shift;  // present next bit on serData
    logic clear;  // return serData to 0
  } dp_ctrl_t;

  function automatic int maxInt(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/xbar_prog_ctrl.sv
module xbar_prog_ctrl
  import xbar_prog_pkg::*;
#(
  parameter int WORD_W        = 32,
  parameter int HALF_CNT      = 12,
  parameter int SETUP_CNT     = 4,
  parameter int LATCH_CNT     = 12,
  parameter int LEAD_GAP_CNT  = 12,
  parameter int TRAIL_GAP_CNT = 12
) (
  input  logic     clk,
  input  logic     rst,
  input  logic     startReq,
  output dp_ctrl_t dpCtrl,
  output logic     serClk,
  output logic     latchEn,
  output logic     busy,
  output logic     done
);

  localparam int MAX_CNT = maxInt(maxInt(HALF_CNT, LATCH_CNT),
                                  maxInt(LEAD_GAP_CNT, TRAIL_GAP_CNT));
  localparam int CNT_W   = $clog2(MAX_CNT + 1);
  localparam int BIT_W   = $clog2(WORD_W);

  localparam logic [CNT_W-1:0] HALF_LAST  = CNT_W'(HALF_CNT - 1);
  localparam logic [CNT_W-1:0] SHIFT_AT   = CNT_W'(HALF_CNT - SETUP_CNT - 1);
  localparam logic [CNT_W-1:0] LATCH_LAST = CNT_W'(LATCH_CNT - 1);
  localparam logic [CNT_W-1:0] LEAD_LAST  = CNT_W'(LEAD_GAP_CNT - 1);
  localparam logic [CNT_W-1:0] TRAIL_LAST = CNT_W'(TRAIL_GAP_CNT - 1);
  localparam logic [BIT_W-1:0] BIT_LAST   = BIT_W'(WORD_W - 1);

  phase_t           phase;
  logic [CNT_W-1:0] cnt;
  logic [BIT_W-1:0] bitIdx;
  logic             doneReg;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase   <= PH_IDLE;
      cnt     <= '0;
      bitIdx  <= '0;
      doneReg <= 1'b0;
    end else begin
      doneReg <= 1'b0;
      case (phase)
        PH_IDLE: begin
          if (startReq) begin
            phase  <= PH_LOW;
            cnt    <= '0;
            bitIdx <= '0;
          end
        end
        PH_LOW: begin
          if (cnt == HALF_LAST) begin
            phase <= PH_HIGH;
            cnt   <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        PH_HIGH: begin
          if (cnt == HALF_LAST) begin
            cnt <= '0;
            if (bitIdx == BIT_LAST) begin
              phase <= PH_LEAD;
            end else begin
              phase  <= PH_LOW;
              bitIdx <= bitIdx + 1'b1;
            end
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        PH_LEAD: begin
          if (cnt == LEAD_LAST) begin
            phase <= PH_LATCH;
            cnt   <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        PH_LATCH: begin
          if (cnt == LATCH_LAST) begin
            phase <= PH_TRAIL;
            cnt   <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        PH_TRAIL: begin
          if (cnt == TRAIL_LAST) begin
            phase   <= PH_IDLE;
            cnt     <= '0;
            doneReg <= 1'b1;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

  always_comb begin
    dpCtrl.load  = (phase == PH_IDLE) && startReq;
    dpCtrl.shift = (phase == PH_LOW) && (cnt == SHIFT_AT);
    dpCtrl.clear = (phase == PH_TRAIL) && (cnt == TRAIL_LAST);
  end

  assign serClk  = (phase == PH_HIGH);
  assign latchEn = (phase == PH_LATCH);
  assign busy    = (phase != PH_IDLE);
  assign done    = doneReg;

endmodule

// File: rtl/xbar_prog_dp.sv
module xbar_prog_dp
  import xbar_prog_pkg::*;
#(
  parameter int NUM_IN  = 4,
  parameter int NUM_OUT = 6,
  parameter int GROUP_W = 8
) (
  input  logic                       clk,
  input  logic                       rst,
  input  dp_ctrl_t                   dpCtrl,
  input  logic [NUM_IN*NUM_OUT-1:0]  mapIn,
  output logic                       serData
);

  localparam int WORD_W = NUM_IN * GROUP_W;

  logic [WORD_W-1:0] packedWord;
  logic [WORD_W-1:0] shiftReg;

  for (genvar gi = 0; gi < NUM_IN; gi++) begin : g_in
    for (genvar gb = 0; gb < GROUP_W; gb++) begin : g_bit
      if (gb < NUM_OUT) begin : g_used
        assign packedWord[gi*GROUP_W+gb] = mapIn[gi*NUM_OUT+gb];
      end else begin : g_pad
        assign packedWord[gi*GROUP_W+gb] = 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      shiftReg <= '0;
      serData  <= 1'b0;
    end else begin
      if (dpCtrl.load) begin
        shiftReg <= packedWord;
      end else if (dpCtrl.shift) begin
        shiftReg <= shiftReg >> 1;
      end
      if (dpCtrl.shift) begin
        serData <= shiftReg[0];
      end else if (dpCtrl.clear) begin
        serData <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/xbar_prog_master.sv
module xbar_prog_master
  import xbar_prog_pkg::*;
#(
  parameter int NUM_IN        = 4,
  parameter int NUM_OUT       = 6,
  parameter int GROUP_W       = 8,
  parameter int SYS_PERIOD_PS = 5000,
  parameter int HALF_CNT      = 12,
  parameter int SETUP_CNT     = 4,
  parameter int LATCH_CNT     = 12,
  parameter int LEAD_GAP_CNT  = 12,
  parameter int TRAIL_GAP_CNT = 12
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [NUM_IN*NUM_OUT-1:0] mapIn,
  input  logic                      startReq,
  output logic                      serClk,
  output logic                      serData,
  output logic                      latchEn,
  output logic                      busy,
  output logic                      done
);

  localparam int WORD_W     = NUM_IN * GROUP_W;
  localparam int MIN_HALF   = 60000;
  localparam int MIN_PERIOD = 100000;
  localparam int MIN_SETUP  = 20000;
  localparam int MIN_HOLD   = 20000;
  localparam int MIN_LATCH  = 60000;
  localparam int MIN_GAP    = 60000;

  if (GROUP_W < NUM_OUT) begin : g_bad_group
    $error("group width too small for output count");
  end
  if (HALF_CNT * SYS_PERIOD_PS < MIN_HALF ||
      2 * HALF_CNT * SYS_PERIOD_PS < MIN_PERIOD) begin : g_bad_half
    $error("serial clock half period too short");
  end
  if (SETUP_CNT < 1 || SETUP_CNT > HALF_CNT ||
      SETUP_CNT * SYS_PERIOD_PS < MIN_SETUP) begin : g_bad_setup
    $error("data setup count out of range");
  end
  if ((2 * HALF_CNT - SETUP_CNT) * SYS_PERIOD_PS < MIN_HOLD) begin : g_bad_hold
    $error("data hold time too short");
  end
  if (LATCH_CNT * SYS_PERIOD_PS < MIN_LATCH) begin : g_bad_latch
    $error("latch pulse too short");
  end
  if (LEAD_GAP_CNT * SYS_PERIOD_PS < MIN_GAP ||
      TRAIL_GAP_CNT * SYS_PERIOD_PS < MIN_GAP) begin : g_bad_gap
    $error("latch gap too short");
  end

  dp_ctrl_t dpCtrl;

  xbar_prog_ctrl #(
    .WORD_W        (WORD_W),
    .HALF_CNT      (HALF_CNT),
    .SETUP_CNT     (SETUP_CNT),
    .LATCH_CNT     (LATCH_CNT),
    .LEAD_GAP_CNT  (LEAD_GAP_CNT),
    .TRAIL_GAP_CNT (TRAIL_GAP_CNT)
  ) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .startReq (startReq),
    .dpCtrl   (dpCtrl),
    .serClk   (serClk),
    .latchEn  (latchEn),
    .busy     (busy),
    .done     (done)
  );

  xbar_prog_dp #(
    .NUM_IN  (NUM_IN),
    .NUM_OUT (NUM_OUT),
    .GROUP_W (GROUP_W)
  ) u_dp (
    .clk     (clk),
    .rst     (rst),
    .dpCtrl  (dpCtrl),
    .mapIn   (mapIn),
    .serData (serData)
  );

endmodule

// File: rtl/xbar_prog_checker.sv
module xbar_prog_checker #(
  parameter int HALF_CNT  = 12,
  parameter int LATCH_CNT = 12
) (
  input logic clk,
  input logic rst,
  input logic startReq,
  input logic serClk,
  input logic serData,
  input logic latchEn,
  input logic busy,
  input logic done
);

  logic [31:0] hiRun;
  logic [31:0] leRun;

  always_ff @(posedge clk) begin
    if (rst) begin
      hiRun <= '0;
      leRun <= '0;
    end else begin
      hiRun <= serClk  ? hiRun + 1 : '0;
      leRun <= latchEn ? leRun + 1 : '0;
    end
  end

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (!serClk && !latchEn));

  assert_clk_high_width_R6: assert property (@(posedge clk) disable iff (rst)
    $fell(serClk) |-> (hiRun == HALF_CNT));

  assert_data_stable_high_R7: assert property (@(posedge clk) disable iff (rst)
    serClk |-> $stable(serData));

  assert_latch_width_R8: assert property (@(posedge clk) disable iff (rst)
    $fell(latchEn) |-> (leRun == LATCH_CNT));

  assert_clk_latch_excl_R8: assert property (@(posedge clk) disable iff (rst)
    !(serClk && latchEn));

  assert_start_needed_R9: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(startReq));

  assert_done_single_R11: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  assert_done_not_busy_R11: assert property (@(posedge clk) disable iff (rst)
    done |-> (!busy && !serData));

endmodule

bind xbar_prog_master xbar_prog_checker #(
  .HALF_CNT  (HALF_CNT),
  .LATCH_CNT (LATCH_CNT)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .startReq (startReq),
  .serClk   (serClk),
  .serData  (serData),
  .latchEn  (latchEn),
  .busy     (busy),
  .done     (done)
);

// File: tb/xbar_prog_master_tb.sv
`timescale 1ns/1ps
module xbar_prog_master_tb;

  localparam int NI = 4, NO = 6, GW = 8, WW = 32, MW = 24;
  localparam int HALF = 12, SETUP = 4, LATCH = 12, LEAD = 12, TRAIL = 12;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic startReq = 1'b0;
  logic [MW-1:0] mapIn = '0;
  logic serClk, serData, latchEn, busy, done;

  always #2.5 clk = ~clk;

  xbar_prog_master u_dut (
    .clk(clk), .rst(rst), .mapIn(mapIn), .startReq(startReq),
    .serClk(serClk), .serData(serData), .latchEn(latchEn),
    .busy(busy), .done(done)
  );

  int testsRun = 0;
  int testsFailed = 0;
  int cycles = 0;
  int transfers = 0;
  bit finished = 0;

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    testsRun++;
    if (!ok) begin
      testsFailed++;
      $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  // reference model: expected {serClk, serData, latchEn, busy, done} per cycle
  logic [4:0] expQ[$];
  logic [4:0] cur = '0;
  logic [WW-1:0] expWord = '0;

  function automatic logic [WW-1:0] packMap(input logic [MW-1:0] m);
    logic [WW-1:0] w = '0;
    for (int i = 0; i < NI; i++)
      for (int j = 0; j < NO; j++)
        w[i*GW+j] = m[i*NO+j];
    return w;
  endfunction

  task automatic buildSeq(input logic [WW-1:0] w);
    logic prev = 1'b0;
    for (int k = 0; k < WW; k++) begin
      for (int c = 0; c < HALF; c++)
        expQ.push_back({1'b0, (c >= HALF - SETUP) ? w[k] : prev, 1'b0, 1'b1, 1'b0});
      for (int c = 0; c < HALF; c++)
        expQ.push_back({1'b1, w[k], 1'b0, 1'b1, 1'b0});
      prev = w[k];
    end
    for (int c = 0; c < LEAD; c++)  expQ.push_back({1'b0, prev, 1'b0, 1'b1, 1'b0});
    for (int c = 0; c < LATCH; c++) expQ.push_back({1'b0, prev, 1'b1, 1'b1, 1'b0});
    for (int c = 0; c < TRAIL; c++) expQ.push_back({1'b0, prev, 1'b0, 1'b1, 1'b0});
    expQ.push_back(5'b00001);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (rst) begin
      expQ.delete();
      cur = '0;
    end else begin
      if (expQ.size() == 0 && startReq) begin
        expWord = packMap(mapIn);
        buildSeq(expWord);
        transfers++;
      end
      if (expQ.size() != 0) cur = expQ.pop_front();
      else cur = '0;
    end
  end

  // per-cycle comparison and word capture
  logic prevClk = 1'b0, prevLe = 1'b0;
  logic [WW-1:0] capWord = '0;
  logic [WW-1:0] lastWord = '0;
  int capIdx = 0;

  always @(negedge clk) begin
    if (!rst && !finished) begin
      check(serClk  === cur[4], "R6 serClk",  {31'b0, serClk},  {31'b0, cur[4]});
      check(serData === cur[3], "R7 serData", {31'b0, serData}, {31'b0, cur[3]});
      check(latchEn === cur[2], "R8 latchEn", {31'b0, latchEn}, {31'b0, cur[2]});
      check(busy    === cur[1], "R11 busy",   {31'b0, busy},    {31'b0, cur[1]});
      check(done    === cur[0], "R11 done",   {31'b0, done},    {31'b0, cur[0]});
      if (serClk && !prevClk) begin
        if (capIdx < WW) capWord[capIdx] = serData;
        capIdx++;
      end
      if (latchEn && !prevLe) begin
        check(capIdx == WW, "R3 edge count", capIdx, WW);
        check(capWord == expWord, "R2 word", capWord, expWord);
        lastWord = capWord;
        capIdx = 0;
      end
      prevClk = serClk;
      prevLe  = latchEn;
    end
  end

  task automatic waitIdle();
    do @(negedge clk); while (busy || expQ.size() != 0);
    @(negedge clk);
  endtask

  task automatic runMap(input logic [MW-1:0] m);
    @(negedge clk);
    mapIn = m;
    startReq = 1'b1;
    @(negedge clk);
    startReq = 1'b0;
    waitIdle();
  endtask

  always @(posedge clk) begin
    if (cycles > 150000 && !finished) begin
      finished = 1;
      testsFailed++;
      $display("FAIL watchdog R11 actual=%0d expected=%0d", cycles, 150000);
      $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check({serClk, serData, latchEn, busy, done} == 5'b0, "R1 reset idle",
          {27'b0, serClk, serData, latchEn, busy, done}, 32'h0);

    // R2 single connection, input 1 to output 4
    runMap(24'h000008);
    check(lastWord == 32'h00000008, "R2 single bit", lastWord, 32'h00000008);

    // R4 R5 all ones
    runMap(24'hFFFFFF);
    check(lastWord == 32'h3F3F3F3F, "R4 unused zero", lastWord, 32'h3F3F3F3F);
    check(lastWord[5:0] == 6'h3F, "R5 multi outputs", {26'b0, lastWord[5:0]}, 32'h3F);

    // R3 distinct pattern: input 4 to output 6, input 2 to output 1
    runMap(24'h800040);
    check(lastWord == 32'h20000100, "R3 ordering", lastWord, 32'h20000100);

    // R9 R10 restart attempt and map change while busy
    @(negedge clk);
    mapIn = 24'h000001;
    startReq = 1'b1;
    @(negedge clk);
    startReq = 1'b0;
    repeat (100) @(negedge clk);
    mapIn = 24'hFFFFFF;
    startReq = 1'b1;
    @(negedge clk);
    startReq = 1'b0;
    waitIdle();
    check(lastWord == 32'h00000001, "R10 map captured", lastWord, 32'h00000001);
    repeat (40) @(negedge clk);
    check(busy == 1'b0, "R9 ignored start", {31'b0, busy}, 32'h0);

    // R11 start held high across done: next transfer begins at once
    @(negedge clk);
    mapIn = 24'h041041;
    startReq = 1'b1;
    while (!done) @(negedge clk);
    mapIn = 24'h000020;
    @(negedge clk);
    check(busy == 1'b1, "R11 restart on done cycle", {31'b0, busy}, 32'h1);
    startReq = 1'b0;
    waitIdle();
    check(lastWord == 32'h00000020, "R11 second word", lastWord, 32'h00000020);

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

endmodule